// File: doc/BRIEF.md
# Secure Address Decoder

This block sits on a small shared bus and turns the address of the master that currently drives the bus into a one-hot select for one of eight slaves. Beside this normal decoding it hides a protected memory window. Two run-time registers give the lowest and the highest address of the window. An access that falls inside the window from a master without window rights is refused. The block asserts no select, returns an error response and raises a sticky violation flag. The same refusal applies when a master without rights addresses a slave that has been marked untrusted at build time.

The window registers and the flag clear share one configuration write port. Only one configured master ID may use this port. Writes from any other ID change nothing and count as violations. All outputs are registered, so a request presented in one cycle is answered after the next clock edge.

Top module: `secure_addr_decoder`

## Requirements
- R1: After reset, slv_sel is 0, resp_err is 0 and viol_flag is 0. The window registers reset to start=1 and end=0, so the window starts disabled and every mapped address decodes normally.
- R2: The region field is the top four address bits. A request with region k in 0..7 sets slv_sel to (1 << k) one cycle later with resp_err 0. slv_sel never has more than one bit set.
- R3: A request whose region field has its top bit set (region 8..15) gives slv_sel 0 and resp_err 1 one cycle later, and it does not set viol_flag.
- R4: When start <= end, an address with start <= addr <= end (both bounds inclusive) from a master whose bit in MST_TRUST is 0 gives slv_sel 0, resp_err 1 and viol_flag 1 one cycle later. Addresses just outside either bound decode normally.
- R5: A master whose bit in MST_TRUST is 1 reaches addresses inside the window with normal decoding and no violation.
- R6: When start > end the window is disabled, and no address is treated as inside it.
- R7: A request from a master whose MST_TRUST bit is 0 to a slave whose bit in SLV_UNTRUST is 1 gives slv_sel 0, resp_err 1 and viol_flag 1. The same request from a trusted master is decoded normally.
- R8: The configuration port writes the start register when cfg_sel=0 and the end register when cfg_sel=1, only when cfg_mid equals CFG_MID. A write from any other ID leaves both registers and the flag unchanged, except that it sets viol_flag one cycle later.
- R9: viol_flag stays 1 until the master CFG_MID writes cfg_sel=2 with data bit 0 set. If a new violation arrives in the same cycle as that clear, the flag stays 1.
- R10: A cycle without req_valid gives slv_sel 0 and resp_err 0 one cycle later.
- R11: resp_err lasts exactly one cycle for each refused request, and it is never high together with any slv_sel bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_addr | input | ADDR_W | Address from the current master |
| req_mid | input | MID_W | ID of the current master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 start register, 1 end register, 2 flag clear |
| cfg_mid | input | MID_W | ID of the master issuing the configuration write |
| cfg_wdata | input | ADDR_W | Configuration write data |
| slv_sel | output | N_SLV | Registered one-hot slave select |
| resp_err | output | 1 | Registered error response, one cycle per refused request |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
If a window bound register held a wrong value, an access from an untrusted master would show a select where an error is expected, or an error where a select is expected. This shows on the cycle after the first request that lands at the affected edge. For this reason, the tests place requests exactly at both bounds and one address past each. A corrupted flag or a wrong trust decision shows on viol_flag and resp_err on the cycle after the offending request. Because the flag is sticky, a wrong clear or a lost set stays visible until the next explicit clear.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    CFG_START = 2'd0,
    CFG_END   = 2'd1,
    CFG_CLEAR = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic fault;
    logic viol;
  } verdict_t;

endpackage

// File: rtl/sad_window_regs.sv
module sad_window_regs
  import sad_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 2,
  parameter int CFG_MID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MID_W-1:0]  cfg_mid,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] win_start,
  output logic [ADDR_W-1:0] win_end,
  output logic              cfg_deny,
  output logic              cfg_clear
);

  localparam logic [MID_W-1:0] OWNER = MID_W'(CFG_MID);

  logic owner_wr;

  always_comb begin
    owner_wr  = cfg_we && (cfg_mid == OWNER);
    cfg_deny  = cfg_we && (cfg_mid != OWNER);
    cfg_clear = owner_wr && (cfg_sel == CFG_CLEAR) && cfg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_start <= ADDR_W'(1);
      win_end   <= '0;
    end else if (owner_wr) begin
      if (cfg_sel == CFG_START) win_start <= cfg_wdata;
      if (cfg_sel == CFG_END)   win_end   <= cfg_wdata;
    end
  end

endmodule

// File: rtl/sad_region_decode.sv
module sad_region_decode #(
  parameter int N_SLV = 8,
  localparam int IDX_W = $clog2(N_SLV)
) (
  input  logic [IDX_W:0]     region,
  output logic               mapped,
  output logic [N_SLV-1:0]   onehot
);

  assign mapped = ~region[IDX_W];

  for (genvar g = 0; g < N_SLV; g++) begin : g_slot
    assign onehot[g] = mapped && (region[IDX_W-1:0] == IDX_W'(g));
  end

endmodule

// File: rtl/sad_access_check.sv
module sad_access_check
  import sad_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_SLV  = 8,
  parameter int MID_W  = 2,
  parameter logic [(1<<MID_W)-1:0] MST_TRUST = '1,
  parameter logic [N_SLV-1:0]      SLV_UNTRUST = '0
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MID_W-1:0]  mid,
  input  logic [ADDR_W-1:0] win_start,
  input  logic [ADDR_W-1:0] win_end,
  input  logic              mapped,
  input  logic [N_SLV-1:0]  onehot,
  output logic [N_SLV-1:0]  grant,
  output verdict_t          verdict
);

  logic win_on, in_win, mst_ok, slv_bad;

  always_comb begin
    win_on  = (win_start <= win_end);
    in_win  = win_on && (addr >= win_start) && (addr <= win_end);
    mst_ok  = MST_TRUST[mid];
    slv_bad = |(onehot & SLV_UNTRUST);
    verdict.viol  = valid && !mst_ok && (in_win || (mapped && slv_bad));
    verdict.fault = valid && (verdict.viol || !mapped);
    grant = (valid && !verdict.fault) ? onehot : '0;
  end

endmodule

// File: rtl/secure_addr_decoder.sv
module secure_addr_decoder
  import sad_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int N_SLV   = 8,
  parameter int MID_W   = 2,
  parameter int CFG_MID = 0,
  parameter logic [(1<<MID_W)-1:0] MST_TRUST   = 4'b0011,
  parameter logic [N_SLV-1:0]      SLV_UNTRUST = 8'b1000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [MID_W-1:0]  req_mid,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MID_W-1:0]  cfg_mid,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [N_SLV-1:0]  slv_sel,
  output logic              resp_err,
  output logic              viol_flag
);

  localparam int IDX_W = $clog2(N_SLV);

  logic [ADDR_W-1:0] win_start, win_end;
  logic              cfg_deny, cfg_clear;
  logic              mapped;
  logic [N_SLV-1:0]  onehot, grant;
  verdict_t          verdict;

  sad_window_regs #(
    .ADDR_W(ADDR_W), .MID_W(MID_W), .CFG_MID(CFG_MID)
  ) u_win (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_mid(cfg_mid), .cfg_wdata(cfg_wdata),
    .win_start(win_start), .win_end(win_end),
    .cfg_deny(cfg_deny), .cfg_clear(cfg_clear)
  );

  sad_region_decode #(.N_SLV(N_SLV)) u_dec (
    .region(req_addr[ADDR_W-1 -: IDX_W+1]),
    .mapped(mapped),
    .onehot(onehot)
  );

  sad_access_check #(
    .ADDR_W(ADDR_W), .N_SLV(N_SLV), .MID_W(MID_W),
    .MST_TRUST(MST_TRUST), .SLV_UNTRUST(SLV_UNTRUST)
  ) u_chk_acc (
    .valid(req_valid), .addr(req_addr), .mid(req_mid),
    .win_start(win_start), .win_end(win_end),
    .mapped(mapped), .onehot(onehot),
    .grant(grant), .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slv_sel   <= '0;
      resp_err  <= 1'b0;
      viol_flag <= 1'b0;
    end else begin
      slv_sel  <= grant;
      resp_err <= verdict.fault;
      if (verdict.viol || cfg_deny) viol_flag <= 1'b1;
      else if (cfg_clear)           viol_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/sad_checker.sv
module sad_checker
  import sad_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int N_SLV   = 8,
  parameter int MID_W   = 2,
  parameter int CFG_MID = 0,
  parameter logic [(1<<MID_W)-1:0] MST_TRUST = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [MID_W-1:0]  req_mid,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [MID_W-1:0]  cfg_mid,
  input logic              cfg_wbit,
  input logic [ADDR_W-1:0] win_start,
  input logic [ADDR_W-1:0] win_end,
  input logic [N_SLV-1:0]  slv_sel,
  input logic              resp_err,
  input logic              viol_flag
);

  logic prev_valid, prev_hidden, hidden_now, clear_now;

  assign hidden_now = req_valid && !MST_TRUST[req_mid] && (win_start <= win_end)
                      && (req_addr >= win_start) && (req_addr <= win_end);
  assign clear_now  = cfg_we && (cfg_mid == MID_W'(CFG_MID))
                      && (cfg_sel == CFG_CLEAR) && cfg_wbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid  <= 1'b0;
      prev_hidden <= 1'b0;
    end else begin
      prev_valid  <= req_valid;
      prev_hidden <= hidden_now;
    end
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(slv_sel));

  // R11
  err_excl_chk: assert property (@(posedge clk) disable iff (rst) !(resp_err && (|slv_sel)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !prev_valid |-> (slv_sel == '0 && !resp_err));

  // R4
  hide_window_chk: assert property (@(posedge clk) disable iff (rst)
    prev_hidden |-> (slv_sel == '0 && resp_err && viol_flag));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !clear_now) |=> viol_flag);

  // R8
  cfg_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_mid != MID_W'(CFG_MID)) |=> ($stable(win_start) && $stable(win_end) && viol_flag));

endmodule

bind secure_addr_decoder sad_checker #(
  .ADDR_W(ADDR_W), .N_SLV(N_SLV), .MID_W(MID_W),
  .CFG_MID(CFG_MID), .MST_TRUST(MST_TRUST)
) u_sad_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_mid(req_mid), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mid(cfg_mid),
  .cfg_wbit(cfg_wdata[0]), .win_start(win_start), .win_end(win_end),
  .slv_sel(slv_sel), .resp_err(resp_err), .viol_flag(viol_flag)
);

// File: tb/secure_addr_decoder_tb.sv
`timescale 1ns/1ps
module secure_addr_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_mid = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_mid = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  slv_sel;
  logic        resp_err;
  logic        viol_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  secure_addr_decoder u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_mid(req_mid), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mid(cfg_mid),
    .cfg_wdata(cfg_wdata), .slv_sel(slv_sel), .resp_err(resp_err),
    .viol_flag(viol_flag)
  );

  task automatic expect_out(input string tag, input logic [7:0] e_sel,
                            input logic e_err, input logic e_flag);
    checks++;
    if (slv_sel !== e_sel || resp_err !== e_err || viol_flag !== e_flag) begin
      errors++;
      $display("FAIL %s: sel=%h err=%b flag=%b expected sel=%h err=%b flag=%b",
               tag, slv_sel, resp_err, viol_flag, e_sel, e_err, e_flag);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_mid = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] m, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mid = m; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_out("R1 reset outputs", 8'h00, 1'b0, 1'b0);
    do_req(32'h0000_0000, 2'd2);
    expect_out("R1 window disabled at reset", 8'h01, 1'b0, 1'b0);
  endtask

  task automatic t_decode();
    for (int k = 0; k < 7; k++) begin
      do_req({4'(k), 28'h0123456}, 2'd2);
      expect_out("R2 region decode", 8'(1 << k), 1'b0, 1'b0);
    end
    do_req(32'h7FFF_FFFF, 2'd0);
    expect_out("R2 top region", 8'h80, 1'b0, 1'b0);
    idle_cycle();
    expect_out("R10 idle after grant", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_unmapped();
    do_req(32'h9000_0000, 2'd0);
    expect_out("R3 unmapped region", 8'h00, 1'b1, 1'b0);
    do_req(32'hF000_0004, 2'd3);
    expect_out("R3 unmapped high", 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_window();
    cfg_write(2'd0, 2'd0, 32'h2000_1000);
    cfg_write(2'd0, 2'd1, 32'h2000_1FFF);
    do_req(32'h2000_1000, 2'd2);
    expect_out("R4 lower bound hidden", 8'h00, 1'b1, 1'b1);
    cfg_write(2'd0, 2'd2, 32'h1);
    expect_out("R9 clear by owner", 8'h00, 1'b0, 1'b0);
    do_req(32'h2000_1FFF, 2'd3);
    expect_out("R4 upper bound hidden", 8'h00, 1'b1, 1'b1);
    cfg_write(2'd0, 2'd2, 32'h1);
    do_req(32'h2000_2000, 2'd2);
    expect_out("R4 above window", 8'h04, 1'b0, 1'b0);
    do_req(32'h2000_0FFF, 2'd2);
    expect_out("R4 below window", 8'h04, 1'b0, 1'b0);
  endtask

  task automatic t_trusted();
    do_req(32'h2000_1800, 2'd1);
    expect_out("R5 trusted in window", 8'h04, 1'b0, 1'b0);
  endtask

  task automatic t_disable();
    cfg_write(2'd0, 2'd0, 32'h2000_3000);
    do_req(32'h2000_1800, 2'd2);
    expect_out("R6 start>end disabled", 8'h04, 1'b0, 1'b0);
    cfg_write(2'd0, 2'd0, 32'h2000_1000);
  endtask

  task automatic t_bad_slave();
    do_req(32'h7000_0000, 2'd3);
    expect_out("R7 untrusted slave blocked", 8'h00, 1'b1, 1'b1);
    cfg_write(2'd0, 2'd2, 32'h1);
    do_req(32'h7000_0000, 2'd1);
    expect_out("R7 trusted master passes", 8'h80, 1'b0, 1'b0);
  endtask

  task automatic t_cfg_guard();
    cfg_write(2'd2, 2'd0, 32'h2000_3000);
    expect_out("R8 foreign write flagged", 8'h00, 1'b0, 1'b1);
    cfg_write(2'd0, 2'd2, 32'h1);
    do_req(32'h2000_1800, 2'd2);
    expect_out("R8 window unchanged", 8'h00, 1'b1, 1'b1);
    cfg_write(2'd3, 2'd2, 32'h1);
    expect_out("R8 foreign clear ignored", 8'h00, 1'b0, 1'b1);
    cfg_write(2'd0, 2'd2, 32'h0);
    expect_out("R9 clear needs bit0", 8'h00, 1'b0, 1'b1);
    cfg_write(2'd0, 2'd2, 32'h1);
    expect_out("R9 clear", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_sticky();
    do_req(32'h2000_1004, 2'd2);
    expect_out("R11 err on refusal", 8'h00, 1'b1, 1'b1);
    idle_cycle();
    expect_out("R11 err one cycle", 8'h00, 1'b0, 1'b1);
    do_req(32'h1000_0000, 2'd2);
    expect_out("R9 flag held over grant", 8'h02, 1'b0, 1'b1);
    cfg_write(2'd0, 2'd2, 32'h1);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h2000_1100; req_mid = 2'd3;
    cfg_we = 1'b1; cfg_mid = 2'd0; cfg_sel = 2'd2; cfg_wdata = 32'h1;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    expect_out("R9 set beats clear", 8'h00, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_unmapped();
    t_window();
    t_trusted();
    t_disable();
    t_bad_slave();
    t_cfg_guard();
    t_sticky();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule